// File: doc/BRIEF.md
# Receive Destination Address Filter

This block judges whether an arriving frame should be kept by looking only at its 48-bit destination MAC address. Upstream logic presents the address with a one-cycle strobe. Exactly one clock later the block raises a result pulse together with two flags. The accept flag says whether the frame is wanted. The inexact flag says the frame got through only because its address hashed onto a set bit of the multicast table.

Three sources of acceptance are checked in parallel. The first is a bank of 16 exact-match entries, each qualified by its own valid bit. The second is a 4096-bit multicast hash table, built as 128 words of 32 bits. The third is a control word with three bits: accept broadcast, accept any unicast, and accept any multicast. All of this storage sits behind one word-wide register port. Writes take effect on the clock edge, and reads return the stored value combinationally from the address.

Addresses are held with byte 0 (the first byte on the wire) in bits 7:0 of the 48-bit value. Byte 5 is in bits 47:40.

Top module: `rx_addr_filter`

## Requirements
- R1: An exact entry whose valid bit is set matches when its low word equals address bytes 3..0 (byte 0 in bits 7:0) and bits 15:0 of its high word equal bytes 5..4 (byte 4 in bits 7:0). A match accepts the frame and leaves the inexact flag low. A single differing address bit prevents that entry from matching.
- R2: An exact entry whose high word has bit 31 clear never matches, even when its address bits equal the destination address.
- R3: The register map is as follows. The control word is at 0x000, with bit 0 for broadcast accept, bit 1 for unicast promiscuous and bit 2 for multicast promiscuous. Entry i has its low word at 0x100+8*i and its high word at 0x104+8*i. Hash word k is at 0x200+4*k. Every mapped register reads back the value written to it, and any other address reads as zero.
- R4: A destination with bit 0 set is multicast. For a multicast destination the hash table word is chosen by address bits 47:41, and the bit within that word by {bit 40, bits 39:36}. A set bit accepts the frame. A destination with bit 0 clear never consults the hash table.
- R5: With broadcast accept set, the all-ones address is accepted and the inexact flag stays low. With it clear, the all-ones address is handled like any other multicast address.
- R6: Unicast promiscuous accepts every destination with bit 0 clear. Multicast promiscuous accepts every destination with bit 0 set, and the inexact flag stays low.
- R7: The inexact flag is high exactly when the hash table is the only reason for acceptance: no exact match, no broadcast acceptance and no multicast promiscuous mode.
- R8: The result pulse, accept and inexact all register one cycle after the strobe. Accept and inexact hold their values until the next strobe. All three outputs are zero after reset.
- R9: When a register write and an address strobe fall in the same cycle, the decision uses the table contents from before the write. The written value applies from the following strobe onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write enable |
| reg_addr | input | 10 | Register byte address, word aligned |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits 7:0 |
| res_valid | output | 1 | Result pulse, one cycle after da_valid |
| accept | output | 1 | Frame accepted |
| inexact | output | 1 | Accepted only through the hash table |

## Verification
The register port and the lookup path can act on the same clock edge. The sharp cases are a write that clears an entry's valid bit, or sets a hash bit, in exactly the cycle its address is strobed. The bench creates both collisions directly and also lets them occur at random during a long mixed run. It expects the old decision on the colliding strobe and the new decision on the next one. The bench model updates its own copy of the tables only after it has computed the expected result for the colliding strobe.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int MAC_W  = 48;
  localparam int REG_W  = 32;
  localparam int CTRL_W = 3;

  localparam int CTRL_BCAST = 0;
  localparam int CTRL_UPROM = 1;
  localparam int CTRL_MPROM = 2;

  // group (multicast or broadcast) address: least significant bit of byte 0
  function automatic logic is_group(input logic [MAC_W-1:0] a);
    return a[0];
  endfunction

  function automatic logic is_bcast(input logic [MAC_W-1:0] a);
    return &a;
  endfunction

  // exact entry compare: valid in bit 31 of the high word
  function automatic logic entry_match(input logic [REG_W-1:0] lo,
                                       input logic [REG_W-1:0] hi,
                                       input logic [MAC_W-1:0] a);
    return hi[REG_W-1] && (hi[15:0] == a[47:32]) && (lo == a[31:0]);
  endfunction
endpackage

// File: rtl/rxf_exact_bank.sv
module rxf_exact_bank
  import rxf_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [REG_W-1:0] rd_lo,
  output logic [REG_W-1:0] rd_hi,
  input  logic [MAC_W-1:0] da,
  output logic [N_ENT-1:0] hit_vec,
  output logic             hit
);
  logic [REG_W-1:0] lo_q [N_ENT];
  logic [REG_W-1:0] hi_q [N_ENT];

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end else begin
        if (wr_lo && (wr_idx == IDX_W'(i))) lo_q[i] <= wdata;
        if (wr_hi && (wr_idx == IDX_W'(i))) hi_q[i] <= wdata;
      end
    end
    assign hit_vec[i] = entry_match(lo_q[i], hi_q[i], da);
  end

  assign hit   = |hit_vec;
  assign rd_lo = lo_q[rd_idx];
  assign rd_hi = hi_q[rd_idx];
endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table
  import rxf_pkg::*;
#(
  parameter int WORDS = 128,
  localparam int IDX_W = $clog2(WORDS),
  localparam int BIT_W = $clog2(REG_W),
  localparam int KEY_W = IDX_W + BIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [REG_W-1:0] rd_data,
  input  logic [KEY_W-1:0] key,
  output logic             hit
);
  logic [REG_W-1:0] tbl_q [WORDS];
  logic [IDX_W-1:0] key_word;
  logic [BIT_W-1:0] key_bit;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                tbl_q[w] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(w)))   tbl_q[w] <= wdata;
    end
  end

  // upper key bits pick the word, lower key bits pick the bit
  assign key_word = key[KEY_W-1:BIT_W];
  assign key_bit  = key[BIT_W-1:0];
  assign hit      = tbl_q[key_word][key_bit];
  assign rd_data  = tbl_q[rd_idx];
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lookup_en,
  input  logic grp,
  input  logic bcast,
  input  logic exact_hit,
  input  logic hash_hit,
  input  logic [CTRL_W-1:0] ctrl,
  output logic res_valid,
  output logic accept,
  output logic inexact
);
  logic bc_take, uni_take, mc_prom_take, hash_take;
  logic acc_d, inx_d;

  always_comb begin
    bc_take      = bcast && ctrl[CTRL_BCAST];
    uni_take     = !grp && ctrl[CTRL_UPROM];
    mc_prom_take = grp && ctrl[CTRL_MPROM];
    hash_take    = grp && hash_hit;
    acc_d = bc_take || exact_hit || uni_take || mc_prom_take || hash_take;
    inx_d = hash_take && !exact_hit && !bc_take && !mc_prom_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      accept    <= 1'b0;
      inexact   <= 1'b0;
    end else begin
      res_valid <= lookup_en;
      if (lookup_en) begin
        accept  <= acc_d;
        inexact <= inx_d;
      end
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int N_EXACT    = 16,
  parameter int HASH_WORDS = 128,
  parameter int ADDR_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              da_valid,
  input  logic [47:0]       da,
  output logic              res_valid,
  output logic              accept,
  output logic              inexact
);
  localparam int EX_IDX_W = $clog2(N_EXACT);
  localparam int HW_IDX_W = $clog2(HASH_WORDS);
  localparam int KEY_W    = HW_IDX_W + $clog2(REG_W);
  localparam logic [31:0] EXACT_BASE = 32'h100;
  localparam logic [31:0] EXACT_END  = EXACT_BASE + 32'(N_EXACT * 8);
  localparam logic [31:0] HASH_BASE  = 32'h200;
  localparam logic [31:0] HASH_END   = HASH_BASE + 32'(HASH_WORDS * 4);

  logic [31:0] addr32, off_ex, off_h;
  logic sel_ctrl, sel_exact, sel_hash, ex_hi;
  logic [EX_IDX_W-1:0] ex_idx;
  logic [HW_IDX_W-1:0] h_idx;
  logic [CTRL_W-1:0] ctrl_q;
  logic [REG_W-1:0] ex_rd_lo, ex_rd_hi, h_rd;
  logic [N_EXACT-1:0] exact_vec_w;
  logic exact_hit_w, hash_hit_w, grp_w, bc_w;

  // register decode
  assign addr32    = 32'(reg_addr);
  assign sel_ctrl  = (addr32 == 32'h0);
  assign sel_exact = (addr32 >= EXACT_BASE) && (addr32 < EXACT_END);
  assign sel_hash  = (addr32 >= HASH_BASE) && (addr32 < HASH_END);
  assign off_ex    = addr32 - EXACT_BASE;
  assign off_h     = addr32 - HASH_BASE;
  assign ex_idx    = EX_IDX_W'(off_ex >> 3);
  assign ex_hi     = off_ex[2];
  assign h_idx     = HW_IDX_W'(off_h >> 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ctrl_q <= '0;
    else if (reg_wen && sel_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
  end

  rxf_exact_bank #(.N_ENT(N_EXACT)) u_exact (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(reg_wen && sel_exact && !ex_hi),
    .wr_hi(reg_wen && sel_exact && ex_hi),
    .wr_idx(ex_idx), .wdata(reg_wdata),
    .rd_idx(ex_idx), .rd_lo(ex_rd_lo), .rd_hi(ex_rd_hi),
    .da(da), .hit_vec(exact_vec_w), .hit(exact_hit_w)
  );

  rxf_hash_table #(.WORDS(HASH_WORDS)) u_hash (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wen && sel_hash), .wr_idx(h_idx), .wdata(reg_wdata),
    .rd_idx(h_idx), .rd_data(h_rd),
    .key(da[MAC_W-1 -: KEY_W]), .hit(hash_hit_w)
  );

  assign grp_w = is_group(da);
  assign bc_w  = is_bcast(da);

  rxf_decide u_decide (
    .clk(clk), .rst_n(rst_n), .lookup_en(da_valid),
    .grp(grp_w), .bcast(bc_w), .exact_hit(exact_hit_w), .hash_hit(hash_hit_w),
    .ctrl(ctrl_q), .res_valid(res_valid), .accept(accept), .inexact(inexact)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_ctrl)       reg_rdata = 32'(ctrl_q);
    else if (sel_exact) reg_rdata = ex_hi ? ex_rd_hi : ex_rd_lo;
    else if (sel_hash)  reg_rdata = h_rd;
  end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        da_valid,
  input logic [47:0] da,
  input logic        exact_hit,
  input logic        hash_hit,
  input logic [2:0]  ctrl,
  input logic        res_valid,
  input logic        accept,
  input logic        inexact
);
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> res_valid);                                                     // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> !res_valid);                                                   // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> ($stable(accept) && $stable(inexact)));                        // R8
  AST_EXACT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && exact_hit) |=> (accept && !inexact));                           // R1
  AST_BCAST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && (&da) && ctrl[0]) |=> (accept && !inexact));                    // R5
  AST_UPROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !da[0] && ctrl[1]) |=> accept);                                 // R6
  AST_MPROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && da[0] && ctrl[2]) |=> (accept && !inexact));                    // R6
  AST_UNI_NO_HASH: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !da[0] && !exact_hit && !ctrl[1]) |=> !accept);                 // R4
  AST_INEXACT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    inexact |-> accept);                                                         // R7
  AST_HASH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && da[0] && hash_hit && !exact_hit && !ctrl[2] && !((&da) && ctrl[0]))
      |=> (accept && inexact));                                                  // R7
endmodule

bind rx_addr_filter rxf_checker u_rxf_chk (
  .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da),
  .exact_hit(exact_hit_w), .hash_hit(hash_hit_w), .ctrl(ctrl_q),
  .res_valid(res_valid), .accept(accept), .inexact(inexact)
);

// File: tb/rx_addr_filter_tb_top.sv
`timescale 1ns/1ps
module rx_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        da_valid = 1'b0;
  logic [47:0] da = '0;
  logic        res_valid, accept, inexact;

  int tests = 0;
  int fails = 0;

  logic [31:0] m_lo [16];
  logic [31:0] m_hi [16];
  logic [31:0] m_ht [128];
  logic [2:0]  m_ctrl;

  always #5 clk = ~clk;

  rx_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .da_valid(da_valid), .da(da),
    .res_valid(res_valid), .accept(accept), .inexact(inexact)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench view of the tables
  function automatic logic m_exact(input logic [47:0] a);
    logic r = 1'b0;
    for (int i = 0; i < 16; i++)
      if (m_hi[i][31] && m_lo[i] == {a[31:24], a[23:16], a[15:8], a[7:0]}
          && m_hi[i][15:0] == {a[47:40], a[39:32]}) r = 1'b1;
    return r;
  endfunction

  function automatic logic m_hash(input logic [47:0] a);
    logic [7:0] b5 = a[47:40];
    logic [7:0] b4 = a[39:32];
    int w = int'(b5 >> 1);
    int b = int'({b5[0], b4[7:4]});
    return m_ht[w][b];
  endfunction

  function automatic logic m_accept(input logic [47:0] a);
    logic mc = a[0];
    return (m_ctrl[0] && a == 48'hFFFF_FFFF_FFFF) || m_exact(a) ||
           (!mc && m_ctrl[1]) || (mc && (m_ctrl[2] || m_hash(a)));
  endfunction

  function automatic logic m_inexact(input logic [47:0] a);
    return a[0] && m_hash(a) && !m_exact(a) && !m_ctrl[2] &&
           !(m_ctrl[0] && a == 48'hFFFF_FFFF_FFFF);
  endfunction

  task automatic m_write(input logic [9:0] a, input logic [31:0] d);
    int ai = int'(a);
    if (ai == 0) m_ctrl = d[2:0];
    else if (ai >= 256 && ai < 384) begin
      if (((ai - 256) % 8) >= 4) m_hi[(ai - 256) / 8] = d;
      else                        m_lo[(ai - 256) / 8] = d;
    end else if (ai >= 512) m_ht[(ai - 512) / 4] = d;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
    m_write(a, d);
  endtask

  task automatic look(input logic [47:0] a, input string req);
    logic ea, ei;
    @(negedge clk);
    da_valid = 1'b1; da = a;
    ea = m_accept(a); ei = m_inexact(a);
    @(negedge clk);
    da_valid = 1'b0;
    chk({req, " res_valid"}, 64'(res_valid), 64'(1));
    chk({req, " accept"}, 64'(accept), 64'(ea));
    chk({req, " inexact"}, 64'(inexact), 64'(ei));
  endtask

  // write and strobe in the same cycle: old contents decide
  task automatic look_with_write(input logic [47:0] a, input logic [9:0] wa,
                                 input logic [31:0] wd, input string req);
    logic ea, ei;
    @(negedge clk);
    da_valid = 1'b1; da = a;
    reg_wen = 1'b1; reg_addr = wa; reg_wdata = wd;
    ea = m_accept(a); ei = m_inexact(a);
    @(negedge clk);
    da_valid = 1'b0; reg_wen = 1'b0;
    m_write(wa, wd);
    chk({req, " collide accept"}, 64'(accept), 64'(ea));
    chk({req, " collide inexact"}, 64'(inexact), 64'(ei));
  endtask

  task automatic rb(input logic [9:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk({req, " readback"}, 64'(reg_rdata), 64'(exp));
  endtask

  function automatic logic [31:0] lo_of(input logic [47:0] a); return a[31:0]; endfunction
  function automatic logic [31:0] hi_of(input logic [47:0] a, input logic v);
    return {v, 15'h0, a[47:32]};
  endfunction

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [47:0] a0, a15, a3, mc, uc, bc;
    int unsigned seed;
    for (int i = 0; i < 16; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    for (int i = 0; i < 128; i++) m_ht[i] = '0;
    m_ctrl = '0;
    seed = $urandom(32'd7319);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8 reset res_valid", 64'(res_valid), 64'(0));
    chk("R8 reset accept", 64'(accept), 64'(0));
    chk("R8 reset inexact", 64'(inexact), 64'(0));
    rb(10'h000, 32'h0, "R3 ctrl");

    a0  = 48'hCC_BB_AA_21_1B_00;
    a15 = 48'h12_34_56_78_9A_BC;
    a3  = 48'h0F_0E_0D_0C_0B_0A;
    wr(10'h100, lo_of(a0));  wr(10'h104, hi_of(a0, 1'b1));
    wr(10'h178, lo_of(a15)); wr(10'h17C, hi_of(a15, 1'b1));
    wr(10'h118, lo_of(a3));  wr(10'h11C, hi_of(a3, 1'b0));
    look(a0, "R1 entry0");
    look(a15, "R1 entry15");
    look(a0 ^ 48'h0100_0000_0000, "R1 one bit off");
    look(a3, "R2 invalid entry");
    rb(10'h17C, hi_of(a15, 1'b1), "R3 entry15 high");
    rb(10'h178, lo_of(a15), "R3 entry15 low");
    rb(10'h180, 32'h0, "R3 unmapped");

    // hash: word from bits 47:41, bit from {40, 39:36}
    mc = 48'hA5_C0_00_00_00_01;  // word 0x52, bit {1,0xC}=0x1C
    wr(10'h200 + 10'(4 * 8'h52), 32'h1000_0000);
    rb(10'h200 + 10'(4 * 8'h52), 32'h1000_0000, "R3 hash word");
    look(mc, "R4 R7 hash hit");
    uc = mc & ~48'h1;
    look(uc, "R4 unicast ignores hash");
    look(mc ^ 48'h0010_0000_0000, "R4 neighbour bit clear");

    bc = 48'hFFFF_FFFF_FFFF;
    look(bc, "R5 bcast disabled");
    wr(10'h3FC, 32'h8000_0000);
    look(bc, "R5 R7 bcast via hash only");
    wr(10'h000, 32'h1);
    look(bc, "R5 bcast enabled");
    wr(10'h3FC, 32'h0);

    wr(10'h000, 32'h2);
    look(48'h55_44_33_22_11_02, "R6 unicast promisc");
    look(48'h55_44_33_22_11_03, "R6 multicast not promisc");
    wr(10'h000, 32'h4);
    look(48'h55_44_33_22_11_03, "R6 multicast promisc");
    look(mc, "R6 R7 promisc hides inexact");
    look(48'h55_44_33_22_11_02, "R6 unicast not promisc");
    wr(10'h000, 32'h0);

    look_with_write(a0, 10'h104, hi_of(a0, 1'b0), "R9 drop valid");
    look(a0, "R9 after drop");
    look_with_write(uc | 48'h1 ^ 48'h0200_0000_0000, 10'h200 + 10'(4 * 8'h53),
                    32'h1000_0000, "R9 set hash");
    look(uc | 48'h1 ^ 48'h0200_0000_0000, "R9 after set");

    @(negedge clk);
    chk("R8 no pulse when idle", 64'(res_valid), 64'(0));
    chk("R8 accept held", 64'(accept), 64'(m_accept(uc | 48'h1 ^ 48'h0200_0000_0000)));

    for (int it = 0; it < 400; it++) begin
      int unsigned sel = $urandom % 8;
      logic [47:0] a;
      if (sel == 0) wr(10'h000, $urandom);
      else if (sel == 1) begin
        int e = int'($urandom % 16);
        logic [47:0] na = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
        wr(10'(256 + 8 * e), lo_of(na));
        wr(10'(260 + 8 * e), hi_of(na, 1'($urandom)));
      end else if (sel == 2) wr(10'(512 + 4 * ($urandom % 128)), $urandom & $urandom);
      else begin
        int e = int'($urandom % 16);
        case ($urandom % 4)
          0: a = {m_hi[e][15:0], m_lo[e]};
          1: a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFE;
          2: a = ({$urandom, $urandom} & 48'hFFFF_FFFF_FFFF) | 48'h1;
          default: a = 48'hFFFF_FFFF_FFFF;
        endcase
        if ($urandom % 6 == 0)
          look_with_write(a, 10'(512 + 4 * ($urandom % 128)), $urandom, "R9 random");
        else
          look(a, "R1 R4 R6 R7 random");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule